// File: doc/BRIEF.md
# Buffered Delay Pre-Trigger Channel

This block is one channel of a programmable delay unit. Software writes a 16-bit delay through a simple 32-bit register port. The write does not change the delay in force: it goes into a hidden staging register. The staged value is moved into the active delay only when a one-cycle load strobe arrives. This lets software prepare a new delay at any time and have it take effect at a moment of its own choosing.

The channel compares the active delay with a free-running cycle counter that is supplied from outside the block. When the two are equal and the channel is enabled, it emits a one-clock pre-trigger pulse. A read of the register returns the delay in force, not the staged one. The upper half of the register is reserved.

Top module: `dly_pretrig_chan`

## Requirements
- R1: After reset the staged and active delays are zero, `pre_trig` is low, and a read returns 0x00000000.
- R2: A write (`reg_sel`=1, `reg_we`=1, `load_ok`=0) changes only the staged delay. The value read back stays the previous active delay.
- R3: `load_ok` high for one cycle without a write copies the staged delay into the active delay at that clock edge. A read in the next cycle returns it.
- R4: When a write and `load_ok` fall in the same cycle, the active delay takes the newly written value at that edge.
- R5: Read data bits 31:16 are always zero. Write data bits 31:16 are discarded, and only bits 15:0 hold the delay.
- R6: If `chan_en` is high and `cnt_val` equals the active delay in cycle t, but did not match in cycle t-1, then `pre_trig` is high in cycle t+1.
- R7: While `chan_en` is low no match is taken, and `pre_trig` is low in the following cycle.
- R8: `pre_trig` is never high in two consecutive cycles. A counter that stays on the matching value produces one pulse only.
- R9: With `reg_sel` low, writes are ignored and `reg_rdata` reads zero.
- R10: An active delay of zero fires the pre-trigger when the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register address decode hit |
| reg_we | input | 1 | Write enable, qualified by reg_sel |
| reg_wdata | input | 32 | Write data; bits 15:0 carry the delay |
| reg_rdata | output | 32 | Read data: the active delay, upper half zero |
| load_ok | input | 1 | One-cycle strobe that commits the staged delay |
| chan_en | input | 1 | Channel enable for the pre-trigger |
| cnt_val | input | 16 | External free-running cycle counter |
| pre_trig | output | 1 | Registered one-clock pre-trigger pulse |

## Verification
Two functions can collide in one clock: a bus write to the staging register and the load strobe. The bench provokes this both in a directed step and repeatedly in a random phase. It checks that the active delay read back takes the value written in that same cycle, not the older staged value. The second collision is a load that moves the active delay onto the value the counter currently holds. A per-clock reference model decides whether a pulse is due, judging the compare against the delay that was in force before the edge.

// File: rtl/dlyc_pkg.sv
package dlyc_pkg;

    // Kind of update applied to the delay registers in one cycle
    typedef enum logic [1:0] {
        UPD_NONE    = 2'b00,
        UPD_STAGE   = 2'b01,
        UPD_COMMIT  = 2'b10,
        UPD_BOTH    = 2'b11
    } upd_kind_e;

    function automatic upd_kind_e classify_upd(input logic wr_hit, input logic commit);
        return upd_kind_e'({commit, wr_hit});
    endfunction

endpackage

// File: rtl/dlyc_store.sv
module dlyc_store
    import dlyc_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [DLY_W-1:0] wr_val,
    input  logic             commit,
    output logic [DLY_W-1:0] staged,
    output logic [DLY_W-1:0] active
);

    typedef struct packed {
        logic [DLY_W-1:0] staged;
        logic [DLY_W-1:0] active;
    } store_t;

    store_t st_d, st_q;
    upd_kind_e kind;

    always_comb begin
        kind = classify_upd(wr_hit, commit);
        st_d = st_q;
        case (kind)
            UPD_STAGE: begin
                st_d.staged = wr_val;
            end
            UPD_COMMIT: begin
                st_d.active = st_q.staged;
            end
            UPD_BOTH: begin
                // the same-cycle write is captured first, then committed
                st_d.staged = wr_val;
                st_d.active = wr_val;
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign staged = st_q.staged;
    assign active = st_q.active;

endmodule

// File: rtl/dlyc_match.sv
module dlyc_match #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DLY_W-1:0] cnt,
    input  logic [DLY_W-1:0] delay,
    output logic             fire
);

    typedef struct packed {
        logic hit_prev;
        logic fire;
    } match_t;

    match_t m_d, m_q;
    logic   hit_now;

    always_comb begin
        hit_now      = en && (cnt == delay);
        m_d          = m_q;
        m_d.hit_prev = hit_now;
        // one pulse per match episode, even if the counter stalls
        m_d.fire     = hit_now && !m_q.hit_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign fire = m_q.fire;

endmodule

// File: rtl/dlyc_readout.sv
module dlyc_readout #(
    parameter int DLY_W = 16,
    parameter int REG_W = 32
) (
    input  logic             sel,
    input  logic [DLY_W-1:0] active,
    output logic [REG_W-1:0] rdata
);

    localparam int PAD_W = REG_W - DLY_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign rdata = sel ? {{PAD_W{1'b0}}, active} : '0;
        end else begin : g_nopad
            assign rdata = sel ? active : '0;
        end
    endgenerate

endmodule

// File: rtl/dly_pretrig_chan.sv
module dly_pretrig_chan #(
    parameter int DLY_W = 16,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             load_ok,
    input  logic             chan_en,
    input  logic [DLY_W-1:0] cnt_val,
    output logic             pre_trig
);

    logic             wr_hit;
    logic [DLY_W-1:0] shadow_q;
    logic [DLY_W-1:0] active_q;
    logic             unused_rsv;

    assign wr_hit     = reg_sel && reg_we;
    assign unused_rsv = ^reg_wdata[REG_W-1:DLY_W];

    dlyc_store #(.DLY_W(DLY_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .wr_val (reg_wdata[DLY_W-1:0]),
        .commit (load_ok),
        .staged (shadow_q),
        .active (active_q)
    );

    dlyc_match #(.DLY_W(DLY_W)) u_match (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (chan_en),
        .cnt   (cnt_val),
        .delay (active_q),
        .fire  (pre_trig)
    );

    dlyc_readout #(.DLY_W(DLY_W), .REG_W(REG_W)) u_rd (
        .sel    (reg_sel),
        .active (active_q),
        .rdata  (reg_rdata)
    );

endmodule

// File: rtl/dly_pretrig_chk.sv
module dly_pretrig_chk #(
    parameter int DLY_W = 16,
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_sel,
    input logic             reg_we,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             load_ok,
    input logic             chan_en,
    input logic [DLY_W-1:0] cnt_val,
    input logic             pre_trig,
    input logic [DLY_W-1:0] shadow,
    input logic [DLY_W-1:0] active
);

    p_stage_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_we && !load_ok) |=> $stable(active));

    p_commit_copies_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_ok && !(reg_sel && reg_we)) |=> (active == $past(shadow)));

    p_commit_takes_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_ok && reg_sel && reg_we) |=> (active == $past(reg_wdata[DLY_W-1:0])));

    p_rsv_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:DLY_W] == '0);

    p_fire_on_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pre_trig |-> $past(chan_en && (cnt_val == active)));

    p_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> !pre_trig);

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pre_trig |=> !pre_trig);

    p_unselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_sel && !load_ok) |=> ($stable(shadow) && $stable(active)));

endmodule

bind dly_pretrig_chan dly_pretrig_chk #(.DLY_W(DLY_W), .REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .load_ok   (load_ok),
    .chan_en   (chan_en),
    .cnt_val   (cnt_val),
    .pre_trig  (pre_trig),
    .shadow    (shadow_q),
    .active    (active_q)
);

// File: tb/dly_pretrig_chan_test.sv
`timescale 1ns/1ps
module dly_pretrig_chan_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        load_ok = 1'b0;
    logic        chan_en = 1'b0;
    logic [15:0] cnt_val = '0;
    logic        pre_trig;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    bit finished = 0;

    // behavioural reference state
    int m_stage = 0;
    int m_active = 0;
    bit m_prev_hit = 0;
    bit m_trig = 0;

    always #2 clk = ~clk;

    dly_pretrig_chan uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .load_ok(load_ok),
        .chan_en(chan_en), .cnt_val(cnt_val), .pre_trig(pre_trig)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, model the edge, compare just after it
    task automatic step(input bit sel, input bit we, input logic [31:0] wd,
                        input bit ld, input bit en, input logic [15:0] cnt);
        bit hit;
        reg_sel = sel; reg_we = we; reg_wdata = wd;
        load_ok = ld; chan_en = en; cnt_val = cnt;
        @(posedge clk);
        hit = en && (int'(cnt) == m_active);
        m_trig = hit && !m_prev_hit;
        m_prev_hit = hit;
        if (sel && we) m_stage = int'(wd[15:0]);
        if (ld) m_active = m_stage;
        #1;
        chk("R6 pre_trig model", pre_trig, m_trig);
        chk("R2 rdata model", reg_rdata, sel ? m_active : 0);
        if (pre_trig) pulses++;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 50000);
        chk("R1 watchdog expired", 1, 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        reg_sel = 1'b1;
        #1;
        chk("R1 reset pre_trig", pre_trig, 0);
        chk("R1 reset rdata", reg_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2, R5: write lands in the stage only
        step(1, 1, 32'hABCD_1234, 0, 0, 16'd7);
        chk("R2 read shows active", reg_rdata, 0);
        // R3: commit alone
        step(1, 0, 0, 1, 0, 16'd8);
        chk("R3 commit visible", reg_rdata, 32'h0000_1234);
        chk("R5 upper half zero", reg_rdata[31:16], 0);
        // R4: write and commit together
        step(1, 1, 32'hFFFF_5555, 1, 0, 16'd9);
        chk("R4 same cycle commit", reg_rdata, 32'h0000_5555);
        // R9: unselected write ignored
        step(0, 1, 32'h0000_7777, 0, 0, 16'd10);
        chk("R9 rdata zero unselected", reg_rdata, 0);
        step(1, 0, 0, 1, 0, 16'd11);
        chk("R9 stage untouched", reg_rdata, 32'h0000_5555);

        // R6: sweep through the delay
        pulses = 0;
        for (int c = 16'h5550; c <= 16'h5560; c++) step(1, 0, 0, 0, 1, c[15:0]);
        step(1, 0, 0, 0, 1, 16'h5561);
        chk("R6 one pulse per sweep", pulses, 1);
        // R7: disabled sweep
        pulses = 0;
        for (int c = 16'h5550; c <= 16'h5560; c++) step(1, 0, 0, 0, 0, c[15:0]);
        step(1, 0, 0, 0, 0, 16'h5561);
        chk("R7 no pulse disabled", pulses, 0);
        // R8: stalled counter on the match
        pulses = 0;
        for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 1, 16'h5555);
        step(1, 0, 0, 0, 1, 16'h0001);
        chk("R8 stalled counter single pulse", pulses, 1);
        // R10: delay zero
        step(1, 1, 32'h0, 1, 0, 16'd3);
        pulses = 0;
        step(1, 0, 0, 0, 1, 16'd0);
        step(1, 0, 0, 0, 1, 16'd1);
        chk("R10 zero delay fires", pulses, 1);

        // commit onto the value the counter holds right now
        step(1, 1, 32'h0000_0042, 0, 1, 16'h0042);
        step(1, 0, 0, 1, 1, 16'h0042);
        step(1, 0, 0, 0, 1, 16'h0042);
        step(1, 0, 0, 0, 1, 16'h0043);

        // random phase with the model compared every clock
        for (int i = 0; i < 400; i++) begin
            bit sel = ($urandom_range(0, 3) != 0);
            bit we  = $urandom_range(0, 1);
            bit ld  = ($urandom_range(0, 4) == 0);
            bit en  = ($urandom_range(0, 5) != 0);
            logic [31:0] wd = {$urandom, 16'h0} | 32'($urandom_range(0, 7));
            logic [15:0] c = 16'($urandom_range(0, 7));
            step(sel, we, wd, ld, en, c);
        end

        if (!finished) begin
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule